// File: doc/BRIEF.md
# Precise Exception Commit Tracker

This block follows every instruction of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback) and keeps exception reporting precise. While an instruction sits in one of the first four stages, that stage may post a fault for it. The fault is not acted on right away. It is stored as one bit in a small per-instruction vector that moves down the pipe with the instruction, alongside its PC, its valid bit and its two write intents (register file and data memory).

The vector is examined only as the instruction leaves the memory stage, which is the commit point. If any bit is set, the instruction's own writes are blocked. Every younger instruction is squashed in the same cycle. A one-cycle trap pulse is then raised, carrying the encoded cause, the faulting PC and a fixed handler address for the fetch redirect. Because only the oldest instruction is ever examined, faults are reported in the order a non-pipelined machine would raise them.

Top module: `commit_trap_unit`

## Requirements
- R1: A fault is acted on only when its instruction leaves the memory stage while `stall` is low. The trap pulse appears in the cycle after the instruction occupied the memory stage, and never while the instruction is still in fetch, decode, execute or memory.
- R2: Once an instruction has any fault posted, its memory write (`mem_wr_en`, which is asserted while the instruction is in the memory stage) stays low. Its register write (`wb_rf_we`, asserted in writeback) also stays low. A clean instruction with a write intent asserts both.
- R3: When one instruction holds several faults, the earliest stage wins. `trap_cause` is coded 0 for fetch, 1 for decode, 2 for execute and 3 for memory.
- R4: When an older instruction traps, a fault already posted earlier in time by a younger instruction is discarded and never reported.
- R5: A fault in a younger instruction never pre-empts an older clean instruction. The older one reaches writeback with its write, and only then does the younger one trap.
- R6: In the cycle a trap is taken, every younger instruction in fetch, decode, execute and memory is squashed. None of them later reaches writeback (`wb_valid` stays 0) or writes memory.
- R7: `trap_valid` is a single-cycle pulse. While it is high, `trap_pc` holds the faulting PC, `wb_pc` equals it, and `redirect_pc` equals the `HANDLER_PC` parameter.
- R8: While `stall` is high, all stage state is frozen. The fetch input is ignored, no trap is taken, and the writeback outputs hold.
- R9: While `rst_n` is low, every valid bit, fault vector and trap output is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Freezes every stage register |
| fetch_valid | input | 1 | An instruction enters fetch this cycle |
| fetch_pc | input | PC_W | PC of the entering instruction |
| post_if | input | 1 | Fetch fault for the instruction in fetch |
| post_id | input | 1 | Illegal-opcode fault for the instruction in decode |
| post_ex | input | 1 | Overflow fault for the instruction in execute |
| post_mem | input | 1 | Data-access fault for the instruction in memory |
| id_rf_we | input | 1 | Register-write intent of the instruction in decode |
| id_mem_we | input | 1 | Memory-write intent of the instruction in decode |
| mem_wr_en | output | 1 | Gated memory write for the instruction leaving memory |
| wb_valid | output | 1 | Writeback slot holds an instruction |
| wb_pc | output | PC_W | PC in writeback |
| wb_rf_we | output | 1 | Gated register-file write in writeback |
| trap_valid | output | 1 | One-cycle trap pulse |
| trap_cause | output | 2 | Encoded cause of the trap |
| trap_pc | output | PC_W | PC of the faulting instruction |
| redirect_pc | output | PC_W | Handler address for the fetch redirect |

## Verification
Single faults are posted from decode and from memory. Each one shows whether the trap waits for the commit point and whether the faulting instruction's writes are blocked. Several faults on one instruction, in fetch+execute and in execute+memory, separate earliest-stage priority from latest-stage or highest-code priority. Two-instruction streams cover both orders. In one, a younger instruction faults earlier in time than an older instruction that faults later; the older fault must win and the younger one must vanish. In the other, a clean older instruction is followed by a faulting one; the older one must commit first. A stall held over a pending trap, with a fetch offered during the stall, shows that the pipe is frozen rather than drained.

// File: rtl/ctu_pkg.sv
package ctu_pkg;
  localparam int unsigned CTU_NSTAGE = 4;
  localparam int unsigned CTU_CW     = $clog2(CTU_NSTAGE);

  typedef enum logic [CTU_CW-1:0] {
    CAUSE_FETCH  = 2'd0,
    CAUSE_DECODE = 2'd1,
    CAUSE_EXEC   = 2'd2,
    CAUSE_MEMORY = 2'd3
  } ctu_cause_e;
endpackage

// File: rtl/ctu_stage_reg.sv
module ctu_stage_reg #(
  parameter int unsigned PC_W = 32,
  parameter int unsigned NEXC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            flush,
  input  logic            d_valid,
  input  logic [PC_W-1:0] d_pc,
  input  logic [NEXC-1:0] d_exc,
  input  logic            d_rf_we,
  input  logic            d_mem_we,
  output logic            q_valid,
  output logic [PC_W-1:0] q_pc,
  output logic [NEXC-1:0] q_exc,
  output logic            q_rf_we,
  output logic            q_mem_we
);
  logic            n_valid;
  logic [PC_W-1:0] n_pc;
  logic [NEXC-1:0] n_exc;
  logic            n_rf_we;
  logic            n_mem_we;

  // next-state: hold, load, or insert a bubble
  always_comb begin
    n_valid  = q_valid;
    n_pc     = q_pc;
    n_exc    = q_exc;
    n_rf_we  = q_rf_we;
    n_mem_we = q_mem_we;
    if (en) begin
      if (flush) begin
        n_valid  = 1'b0;
        n_exc    = '0;
        n_rf_we  = 1'b0;
        n_mem_we = 1'b0;
      end else begin
        n_valid  = d_valid;
        n_pc     = d_pc;
        n_exc    = d_valid ? d_exc : '0;
        n_rf_we  = d_valid & d_rf_we;
        n_mem_we = d_valid & d_mem_we;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid  <= 1'b0;
      q_pc     <= '0;
      q_exc    <= '0;
      q_rf_we  <= 1'b0;
      q_mem_we <= 1'b0;
    end else begin
      q_valid  <= n_valid;
      q_pc     <= n_pc;
      q_exc    <= n_exc;
      q_rf_we  <= n_rf_we;
      q_mem_we <= n_mem_we;
    end
  end
endmodule

// File: rtl/ctu_cause_enc.sv
module ctu_cause_enc #(
  parameter int unsigned N  = 4,
  localparam int unsigned CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [CW-1:0] code
);
  // lowest index = earliest pipe stage wins
  always_comb begin
    any  = |vec;
    code = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) code = CW'(i);
    end
  end
endmodule

// File: rtl/commit_trap_unit.sv
module commit_trap_unit #(
  parameter int unsigned      PC_W       = 32,
  parameter logic [PC_W-1:0]  HANDLER_PC = 'h180
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stall,
  input  logic            fetch_valid,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            post_if,
  input  logic            post_id,
  input  logic            post_ex,
  input  logic            post_mem,
  input  logic            id_rf_we,
  input  logic            id_mem_we,
  output logic            mem_wr_en,
  output logic            wb_valid,
  output logic [PC_W-1:0] wb_pc,
  output logic            wb_rf_we,
  output logic            trap_valid,
  output logic [1:0]      trap_cause,
  output logic [PC_W-1:0] trap_pc,
  output logic [PC_W-1:0] redirect_pc
);
  import ctu_pkg::*;

  localparam int unsigned NST  = CTU_NSTAGE;
  localparam int unsigned CW   = CTU_CW;
  localparam int unsigned LAST = NST - 1;
  localparam int unsigned DEC  = 1;

  logic [NST-1:0]  post_vec;
  logic            s_valid  [NST];
  logic [PC_W-1:0] s_pc     [NST];
  logic [NST-1:0]  s_exc    [NST];
  logic            s_rf     [NST];
  logic            s_mw     [NST];
  logic [NST-1:0]  eff_exc  [NST];

  logic            adv;
  logic            take_trap;
  logic            commit_any;
  logic [CW-1:0]   commit_code;

  assign post_vec = {post_mem, post_ex, post_id, post_if};
  assign adv      = ~stall;

  genvar k;
  generate
    for (k = 0; k < NST; k++) begin : g_stage
      logic [NST-1:0]  hit;
      logic            d_valid;
      logic [PC_W-1:0] d_pc;
      logic [NST-1:0]  d_exc;
      logic            d_rf;
      logic            d_mw;

      assign hit        = (post_vec[k] & s_valid[k]) ? (NST'(1) << k) : '0;
      assign eff_exc[k] = s_exc[k] | hit;

      if (k == 0) begin : g_head
        assign d_valid = fetch_valid;
        assign d_pc    = fetch_pc;
        assign d_exc   = '0;
        assign d_rf    = 1'b0;
        assign d_mw    = 1'b0;
      end else begin : g_body
        logic up_clean;
        assign up_clean = ~|eff_exc[k-1];
        assign d_valid  = s_valid[k-1];
        assign d_pc     = s_pc[k-1];
        assign d_exc    = eff_exc[k-1];
        if (k == DEC + 1) begin : g_intent
          assign d_rf = id_rf_we  & up_clean;
          assign d_mw = id_mem_we & up_clean;
        end else begin : g_carry
          assign d_rf = s_rf[k-1] & up_clean;
          assign d_mw = s_mw[k-1] & up_clean;
        end
      end

      ctu_stage_reg #(.PC_W(PC_W), .NEXC(NST)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (adv),
        .flush    (take_trap),
        .d_valid  (d_valid),
        .d_pc     (d_pc),
        .d_exc    (d_exc),
        .d_rf_we  (d_rf),
        .d_mem_we (d_mw),
        .q_valid  (s_valid[k]),
        .q_pc     (s_pc[k]),
        .q_exc    (s_exc[k]),
        .q_rf_we  (s_rf[k]),
        .q_mem_we (s_mw[k])
      );
    end
  endgenerate

  ctu_cause_enc #(.N(NST)) u_enc (
    .vec  (eff_exc[LAST]),
    .any  (commit_any),
    .code (commit_code)
  );

  assign take_trap = adv & s_valid[LAST] & commit_any;
  assign mem_wr_en = adv & s_valid[LAST] & s_mw[LAST] & ~commit_any;

  // writeback slot
  logic            wb_valid_n;
  logic [PC_W-1:0] wb_pc_n;
  logic            wb_rf_n;

  always_comb begin
    wb_valid_n = wb_valid;
    wb_pc_n    = wb_pc;
    wb_rf_n    = wb_rf_we;
    if (adv) begin
      wb_valid_n = s_valid[LAST];
      wb_pc_n    = s_pc[LAST];
      wb_rf_n    = s_valid[LAST] & s_rf[LAST] & ~commit_any;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_pc    <= '0;
      wb_rf_we <= 1'b0;
    end else begin
      wb_valid <= wb_valid_n;
      wb_pc    <= wb_pc_n;
      wb_rf_we <= wb_rf_n;
    end
  end

  // trap report
  logic            trap_n;
  logic [CW-1:0]   cause_n;
  logic [PC_W-1:0] tpc_n;

  always_comb begin
    trap_n  = take_trap;
    cause_n = take_trap ? commit_code : trap_cause;
    tpc_n   = take_trap ? s_pc[LAST]  : trap_pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_valid <= 1'b0;
      trap_cause <= '0;
      trap_pc    <= '0;
    end else begin
      trap_valid <= trap_n;
      trap_cause <= cause_n;
      trap_pc    <= tpc_n;
    end
  end

  assign redirect_pc = HANDLER_PC;
endmodule

module commit_trap_unit_chk #(
  parameter int unsigned PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            stall,
  input logic            mem_wr_en,
  input logic            wb_valid,
  input logic [PC_W-1:0] wb_pc,
  input logic            wb_rf_we,
  input logic            trap_valid,
  input logic [PC_W-1:0] trap_pc
);
  assert_trap_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> !trap_valid);

  assert_trap_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> (wb_valid && wb_pc == trap_pc));

  assert_no_rf_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> !wb_rf_we);

  assert_squash_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> !mem_wr_en);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (wb_valid == $past(wb_valid) && wb_pc == $past(wb_pc) && !trap_valid));

  assert_stall_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !mem_wr_en);
endmodule

bind commit_trap_unit commit_trap_unit_chk #(.PC_W(PC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stall      (stall),
  .mem_wr_en  (mem_wr_en),
  .wb_valid   (wb_valid),
  .wb_pc      (wb_pc),
  .wb_rf_we   (wb_rf_we),
  .trap_valid (trap_valid),
  .trap_pc    (trap_pc)
);

// File: tb/tb_commit_trap_unit.sv
module tb_commit_trap_unit;
  localparam int unsigned PC_W = 32;
  localparam logic [PC_W-1:0] HVEC = 32'h0000_0180;

  logic clk, rst_n, stall, fetch_valid;
  logic [PC_W-1:0] fetch_pc;
  logic post_if, post_id, post_ex, post_mem, id_rf_we, id_mem_we;
  logic mem_wr_en, wb_valid, wb_rf_we, trap_valid;
  logic [PC_W-1:0] wb_pc, trap_pc, redirect_pc;
  logic [1:0] trap_cause;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  logic mwe_seen;

  commit_trap_unit #(.PC_W(PC_W), .HANDLER_PC(HVEC)) dut (
    .clk(clk), .rst_n(rst_n), .stall(stall),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .post_if(post_if), .post_id(post_id), .post_ex(post_ex), .post_mem(post_mem),
    .id_rf_we(id_rf_we), .id_mem_we(id_mem_we),
    .mem_wr_en(mem_wr_en), .wb_valid(wb_valid), .wb_pc(wb_pc), .wb_rf_we(wb_rf_we),
    .trap_valid(trap_valid), .trap_cause(trap_cause), .trap_pc(trap_pc),
    .redirect_pc(redirect_pc)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    stall = 0; fetch_valid = 0; fetch_pc = '0;
    post_if = 0; post_id = 0; post_ex = 0; post_mem = 0;
    id_rf_we = 0; id_mem_we = 0;
  endtask

  // inputs set after a falling edge; one rising edge; registered outputs read after next falling edge
  task automatic tick();
    #1 mwe_seen = mem_wr_en;
    @(negedge clk);
    clear_in();
  endtask

  task automatic fetch(input logic [PC_W-1:0] pc);
    fetch_valid = 1; fetch_pc = pc;
  endtask

  task automatic test_reset();
    chk("R9 trap_valid", trap_valid, 0);
    chk("R9 wb_valid", wb_valid, 0);
    chk("R9 mem_wr_en", mem_wr_en, 0);
  endtask

  task automatic test_clean();
    fetch(32'h100); tick();
    tick();
    id_rf_we = 1; id_mem_we = 1; tick();
    tick();
    tick();
    chk("R2 clean mem write", mwe_seen, 1);
    chk("R2 clean wb_valid", wb_valid, 1);
    chk("R2 clean wb_rf_we", wb_rf_we, 1);
    chk("R1 clean no trap", trap_valid, 0);
  endtask

  task automatic test_decode_fault();
    fetch(32'h200); tick();
    tick();
    post_id = 1; id_rf_we = 1; id_mem_we = 1; tick();
    chk("R1 no trap in decode", trap_valid, 0);
    tick();
    chk("R1 no trap in execute", trap_valid, 0);
    tick();
    chk("R2 faulting mem write blocked", mwe_seen, 0);
    chk("R1 trap at commit", trap_valid, 1);
    chk("R3 cause decode=1", trap_cause, 1);
    chk("R7 trap_pc", trap_pc, 32'h200);
    chk("R7 redirect_pc", redirect_pc, HVEC);
    chk("R2 faulting rf write blocked", wb_rf_we, 0);
    tick();
    chk("R7 single-cycle pulse", trap_valid, 0);
  endtask

  task automatic test_multi(input bit pi, input bit pe, input bit pm, input logic [1:0] exp_c);
    fetch(32'h300); tick();
    post_if = pi; tick();
    tick();
    post_ex = pe; tick();
    post_mem = pm; tick();
    chk("R3 multi-fault trap", trap_valid, 1);
    chk("R3 earliest stage cause", trap_cause, exp_c);
    tick();
  endtask

  task automatic test_older_wins();
    fetch(32'h400); tick();                 // A enters
    fetch(32'h404); tick();                 // B enters, A in fetch
    post_if = 1; tick();                    // B fetch fault, A in decode
    id_mem_we = 1; id_rf_we = 1; tick();    // B in decode, A in execute
    post_mem = 1; tick();                   // A in memory faults
    chk("R4 older trap first", trap_valid, 1);
    chk("R4 older cause memory=3", trap_cause, 3);
    chk("R4 older pc", trap_pc, 32'h400);
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R4 younger fault discarded", trap_valid, 0);
      chk("R6 squashed not in wb", wb_valid, 0);
      chk("R6 squashed no mem write", mwe_seen, 0);
    end
  endtask

  task automatic test_no_preempt();
    fetch(32'h500); tick();                 // A
    fetch(32'h504); tick();                 // B
    id_rf_we = 1; tick();                   // A decode
    post_id = 1; tick();                    // B decode fault
    tick();                                 // A memory
    chk("R5 older commits without trap", trap_valid, 0);
    chk("R5 older in wb", wb_pc, 32'h500);
    chk("R5 older writes rf", wb_rf_we, 1);
    tick();                                 // B memory
    chk("R5 younger traps after", trap_valid, 1);
    chk("R5 younger pc", trap_pc, 32'h504);
    chk("R5 younger cause", trap_cause, 1);
    tick();
  endtask

  task automatic test_stall();
    logic       wv;
    logic [PC_W-1:0] wp;
    fetch(32'h600); tick();
    tick();
    post_id = 1; tick();
    tick();                                 // A now in memory
    wv = wb_valid; wp = wb_pc;
    stall = 1; tick();
    chk("R8 no trap while stalled", trap_valid, 0);
    chk("R8 no mem write while stalled", mwe_seen, 0);
    chk("R8 wb_valid holds", wb_valid, wv);
    chk("R8 wb_pc holds", wb_pc, wp);
    stall = 1; fetch(32'h6F0); tick();
    chk("R8 still no trap", trap_valid, 0);
    tick();
    chk("R8 trap after release", trap_valid, 1);
    chk("R8 trap pc after release", trap_pc, 32'h600);
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R8 stalled fetch ignored", wb_valid, 0);
    end
  endtask

  initial begin
    clear_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1;
    @(negedge clk);
    test_clean();
    test_decode_fault();
    test_multi(1, 1, 0, 2'd0);
    test_multi(0, 1, 1, 2'd2);
    test_older_wins();
    test_no_preempt();
    test_stall();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule